// File: doc/BRIEF.md
# Floating-Point Status Field to Condition Register Move Unit

This unit executes the instruction that copies one 4-bit field of the floating-point status and control register (FPSCR) into one 4-bit field of the condition register (CR). Each cycle it takes a 32-bit instruction word together with the current FPSCR and CR values. It decodes the word, picks the source status field, and places that nibble into the chosen CR field. Within the source field it then resets the sticky exception flags. The rounding mode, result class and fraction-rounded/inexact bits stay as they were. Last, it re-derives the invalid-operation summary (VX) and the enabled-exception summary (FEX).

Results are registered: the next CR, the next FPSCR, a match flag and an illegal-form flag appear on the outputs one clock after the inputs are presented. When the word does not decode as this instruction, or when it carries nonzero reserved bits, both registers pass through unchanged. Field numbering, FPSCR bit names and the instruction fields all use MSB-0 numbering. MSB-0 bit n is vector index 31−n.

Top module: `fpscr_crf_move`

## Requirements
- R1: valid_o is 1 exactly when instr[31:26] equals 63 and instr[10:1] equals 64 (base word 0xFC000080). Otherwise valid_o is 0 and illegal_o is 0.
- R2: The destination index d is instr[25:23] and the source index s is instr[20:18]. The nibble fpscr[31−4s −: 4] is written unchanged into cr[31−4d −: 4], with its MSB landing in the field's LT position.
- R3: CR fields other than field d keep their input values on an executed move.
- R4: After the copy, a bit inside the source field is reset only if it is one of the sticky flags. These are MSB-0 bits 0, 3–12 and 21–23, which is mask 0x9FF80700.
- R5: Every FPSCR bit outside the cleared set and the two summary bits keeps its value, including bits of the source field such as the rounding mode, the result class, FR and FI.
- R6: VX (MSB-0 bit 2, index 29) becomes 1 if any of MSB-0 bits 7–12 or 21–23 (mask 0x01F80700) is still set after the clear, and 0 otherwise.
- R7: FEX (MSB-0 bit 1, index 30) becomes (VX&VE)|(OX&OE)|(UX&UE)|(ZX&ZE)|(XX&XE). VE..XE are MSB-0 bits 24–28 (indices 7..3), OX..XX are MSB-0 bits 3–6 (indices 28..25), and VX is the recomputed value.
- R8: A set reserved bit instr[0] (the record flag) raises illegal_o and leaves all of CR, including field 0, unchanged.
- R9: A nonzero reserved field instr[22:21] or instr[17:11] raises illegal_o, and CR and FPSCR pass through unchanged.
- R10: A non-matching word leaves CR and FPSCR unchanged.
- R11: Outputs are registered with one cycle of latency. An active-low reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| fpscr_i | input | 32 | Current FPSCR |
| cr_i | input | 32 | Current condition register |
| cr_o | output | 32 | Next condition register |
| fpscr_o | output | 32 | Next FPSCR |
| valid_o | output | 1 | Instruction word matched |
| illegal_o | output | 1 | Matched word with nonzero reserved bits |

## Verification
The hardest situation to reach is one where the clear removes the last set invalid-operation flag. VX must then fall, and FEX must either fall with it or be held up by a different enabled exception. The bench builds FPSCR images in which the only invalid flag sits inside the chosen source field, with VE set. In a second image an overflow flag with its enable lies outside that field, so FEX has to stay at 1 while VX drops. A sweep of all 64 source/destination pairs over a patterned FPSCR covers field placement.

// File: rtl/fmv_pkg.sv
package fmv_pkg;
    localparam int XLEN    = 32;
    localparam int FIELD_W = 4;
    localparam int IDX_W   = 3;
    localparam int NFIELDS = XLEN / FIELD_W;

    localparam logic [5:0] PRIM_OP = 6'd63;
    localparam logic [9:0] EXT_OP  = 10'd64;

    // Vector index of MSB-0 status bit n is XLEN-1-n
    localparam int FEX_IX = XLEN - 1 - 1;
    localparam int VX_IX  = XLEN - 1 - 2;
    localparam int OX_IX  = XLEN - 1 - 3;
    localparam int UX_IX  = XLEN - 1 - 4;
    localparam int ZX_IX  = XLEN - 1 - 5;
    localparam int XX_IX  = XLEN - 1 - 6;
    localparam int VE_IX  = XLEN - 1 - 24;
    localparam int OE_IX  = XLEN - 1 - 25;
    localparam int UE_IX  = XLEN - 1 - 26;
    localparam int ZE_IX  = XLEN - 1 - 27;
    localparam int XE_IX  = XLEN - 1 - 28;

    // sticky flags: MSB-0 0, 3..12, 21..23
    localparam logic [XLEN-1:0] STICKY_MASK = 32'h9FF8_0700;
    // invalid-operation detail flags: MSB-0 7..12, 21..23
    localparam logic [XLEN-1:0] VXANY_MASK  = 32'h01F8_0700;

    typedef struct packed {
        logic [XLEN-1:0] cr;
        logic [XLEN-1:0] fpscr;
        logic            valid;
        logic            illegal;
    } fmv_state_t;
endpackage

// File: rtl/fmv_decode.sv
module fmv_decode
    import fmv_pkg::*;
(
    input  logic [XLEN-1:0]  instr_i,
    output logic             match_o,
    output logic             illegal_o,
    output logic [IDX_W-1:0] dst_idx_o,
    output logic [IDX_W-1:0] src_idx_o
);
    logic rsvd_set;

    assign match_o   = (instr_i[31:26] == PRIM_OP) && (instr_i[10:1] == EXT_OP);
    assign rsvd_set  = (|instr_i[22:21]) | (|instr_i[17:11]) | instr_i[0];
    assign illegal_o = match_o && rsvd_set;
    assign dst_idx_o = instr_i[25:23];
    assign src_idx_o = instr_i[20:18];
endmodule

// File: rtl/fmv_field_pick.sv
module fmv_field_pick #(
    parameter int W  = 32,
    parameter int FW = 4,
    parameter int IW = 3
) (
    input  logic [W-1:0]  word_i,
    input  logic [IW-1:0] idx_i,
    output logic [FW-1:0] nib_o,
    output logic [W-1:0]  mask_o
);
    localparam int NF = W / FW;

    for (genvar f = 0; f < NF; f++) begin : g_mask
        assign mask_o[W-1-f*FW -: FW] = (idx_i == IW'(f)) ? {FW{1'b1}} : {FW{1'b0}};
    end

    always_comb begin
        nib_o = '0;
        for (int f = 0; f < NF; f++) begin
            if (idx_i == IW'(f)) nib_o = word_i[W-1-f*FW -: FW];
        end
    end
endmodule

// File: rtl/fmv_cr_insert.sv
module fmv_cr_insert #(
    parameter int W  = 32,
    parameter int FW = 4,
    parameter int IW = 3
) (
    input  logic [W-1:0]  cr_i,
    input  logic [IW-1:0] idx_i,
    input  logic [FW-1:0] nib_i,
    output logic [W-1:0]  cr_o,
    output logic [W-1:0]  mask_o
);
    localparam int NF = W / FW;

    for (genvar f = 0; f < NF; f++) begin : g_fld
        logic hit;
        assign hit = (idx_i == IW'(f));
        assign cr_o[W-1-f*FW -: FW]   = hit ? nib_i : cr_i[W-1-f*FW -: FW];
        assign mask_o[W-1-f*FW -: FW] = hit ? {FW{1'b1}} : {FW{1'b0}};
    end
endmodule

// File: rtl/fmv_status_fix.sv
module fmv_status_fix
    import fmv_pkg::*;
(
    input  logic [XLEN-1:0] fpscr_i,
    input  logic [XLEN-1:0] sel_mask_i,
    output logic [XLEN-1:0] fpscr_o
);
    logic [XLEN-1:0] cleared;
    logic            vx_new;
    logic            fex_new;

    always_comb begin
        cleared = fpscr_i & ~(sel_mask_i & STICKY_MASK);
        vx_new  = |(cleared & VXANY_MASK);
        fex_new = (vx_new          & cleared[VE_IX]) |
                  (cleared[OX_IX]  & cleared[OE_IX]) |
                  (cleared[UX_IX]  & cleared[UE_IX]) |
                  (cleared[ZX_IX]  & cleared[ZE_IX]) |
                  (cleared[XX_IX]  & cleared[XE_IX]);
        fpscr_o         = cleared;
        fpscr_o[VX_IX]  = vx_new;
        fpscr_o[FEX_IX] = fex_new;
    end
endmodule

// File: rtl/fpscr_crf_move.sv
module fpscr_crf_move
    import fmv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] fpscr_i,
    input  logic [XLEN-1:0] cr_i,
    output logic [XLEN-1:0] cr_o,
    output logic [XLEN-1:0] fpscr_o,
    output logic            valid_o,
    output logic            illegal_o
);
    logic               dec_match;
    logic               dec_illegal;
    logic [IDX_W-1:0]   dst_idx;
    logic [IDX_W-1:0]   src_idx;
    logic [FIELD_W-1:0] src_nib;
    logic [XLEN-1:0]    src_mask;
    logic [XLEN-1:0]    dst_mask;
    logic [XLEN-1:0]    cr_ins;
    logic [XLEN-1:0]    fpscr_fix;
    logic               do_move;
    fmv_state_t         st_d;
    fmv_state_t         st_q;

    fmv_decode u_dec (
        .instr_i   (instr_i),
        .match_o   (dec_match),
        .illegal_o (dec_illegal),
        .dst_idx_o (dst_idx),
        .src_idx_o (src_idx)
    );

    fmv_field_pick #(.W(XLEN), .FW(FIELD_W), .IW(IDX_W)) u_pick (
        .word_i (fpscr_i),
        .idx_i  (src_idx),
        .nib_o  (src_nib),
        .mask_o (src_mask)
    );

    fmv_cr_insert #(.W(XLEN), .FW(FIELD_W), .IW(IDX_W)) u_ins (
        .cr_i   (cr_i),
        .idx_i  (dst_idx),
        .nib_i  (src_nib),
        .cr_o   (cr_ins),
        .mask_o (dst_mask)
    );

    fmv_status_fix u_fix (
        .fpscr_i    (fpscr_i),
        .sel_mask_i (src_mask),
        .fpscr_o    (fpscr_fix)
    );

    assign do_move = dec_match && !dec_illegal;

    always_comb begin
        st_d.valid   = dec_match;
        st_d.illegal = dec_illegal;
        st_d.cr      = do_move ? cr_ins    : cr_i;
        st_d.fpscr   = do_move ? fpscr_fix : fpscr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cr_o      = st_q.cr;
    assign fpscr_o   = st_q.fpscr;
    assign valid_o   = st_q.valid;
    assign illegal_o = st_q.illegal;

    // R1
    illegal_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> valid_o);

    // R3
    cr_other_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_move |=> ((cr_o ^ $past(cr_i)) & ~$past(dst_mask)) == '0);

    // R4
    sticky_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_move |=> (fpscr_o & $past(src_mask) & STICKY_MASK) == '0);

    // R5
    untouched_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_move |=> ((fpscr_o ^ $past(fpscr_i)) & ~STICKY_MASK
                     & ~(32'h1 << VX_IX) & ~(32'h1 << FEX_IX)) == '0);

    // R6
    vx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_move |=> fpscr_o[VX_IX] == (|(fpscr_o & VXANY_MASK)));

    // R9
    illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |=> (cr_o == $past(cr_i)) && (fpscr_o == $past(fpscr_i)));

    // R10
    nomatch_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_match |=> (cr_o == $past(cr_i)) && (fpscr_o == $past(fpscr_i)) && !valid_o);
endmodule

// File: tb/test_fpscr_crf_move.sv
module test_fpscr_crf_move;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'hFC00_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] fpscr_i = '0;
    logic [31:0] cr_i = '0;
    logic [31:0] cr_o;
    logic [31:0] fpscr_o;
    logic        valid_o;
    logic        illegal_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpscr_crf_move i_fpscr_crf_move (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .fpscr_i(fpscr_i), .cr_i(cr_i),
        .cr_o(cr_o), .fpscr_o(fpscr_o), .valid_o(valid_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] mk(input int d, input int s);
        return BASE | (32'(d) << 23) | (32'(s) << 18);
    endfunction

    function automatic bit bit_msb0(input logic [31:0] v, input int n);
        return v[31-n];
    endfunction

    // reference: returns {cr, fpscr} for an executed move
    function automatic logic [63:0] model(input int d, input int s,
                                          input logic [31:0] f, input logic [31:0] c);
        logic [3:0]  nib;
        logic [31:0] nf;
        logic [31:0] nc;
        bit vx;
        bit fex;
        nib = 4'((f >> (28 - 4*s)) & 32'hF);
        nc  = (c & ~(32'hF << (28 - 4*d))) | (32'(nib) << (28 - 4*d));
        nf  = f;
        for (int n = 0; n < 32; n++) begin
            bit sticky;
            sticky = (n == 0) || (n >= 3 && n <= 12) || (n >= 21 && n <= 23);
            if (sticky && (n / 4 == s)) nf[31-n] = 1'b0;
        end
        vx = 0;
        for (int n = 7; n <= 12; n++) vx |= bit_msb0(nf, n);
        for (int n = 21; n <= 23; n++) vx |= bit_msb0(nf, n);
        nf[31-2] = vx;
        fex = vx & bit_msb0(nf, 24);
        for (int k = 0; k < 4; k++) fex |= bit_msb0(nf, 3+k) & bit_msb0(nf, 25+k);
        nf[31-1] = fex;
        return {nc, nf};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] f, input logic [31:0] c);
        @(negedge clk);
        instr_i = ins; fpscr_i = f; cr_i = c;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        instr_i = BASE; fpscr_i = 32'hFFFF_FFFF; cr_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R11 reset cr", cr_o, 32'h0);
        chk("R11 reset fpscr", fpscr_o, 32'h0);
        chk("R11 reset flags", {30'd0, valid_o, illegal_o}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_field0_all_ones;
        apply(mk(5, 0), 32'hFFFF_FFFF, 32'h0);
        chk("R1 valid", {31'd0, valid_o}, 32'h1);
        chk("R2 cr field5", cr_o, 32'h0000_0F00);
        chk("R4 FX/OX cleared", fpscr_o, 32'h6FFF_FFFF);
    endtask

    task automatic t_vx_drop;
        apply(mk(2, 1), 32'h6100_0080, 32'hFFFF_FFFF);
        chk("R3 cr other fields", cr_o, 32'hFF1F_FFFF);
        chk("R6 VX and FEX fall", fpscr_o, 32'h0000_0080);
    endtask

    task automatic t_fex_held;
        apply(mk(0, 5), 32'h7000_04C0, 32'h0);
        chk("R2 cr field0", cr_o, 32'h4000_0000);
        chk("R7 FEX held by OX&OE", fpscr_o, 32'h5000_00C0);
    endtask

    task automatic t_untouched;
        apply(mk(7, 7), 32'h0000_000F, 32'h0);
        chk("R5 rounding/enable kept", fpscr_o, 32'h0000_000F);
        chk("R2 cr field7", cr_o, 32'h0000_000F);
        apply(mk(1, 3), 32'h000F_0000, 32'h0);
        chk("R5 FR/FI/class kept", fpscr_o, 32'h0007_0000);
        chk("R2 cr field1", cr_o, 32'h0F00_0000);
    endtask

    task automatic t_rc;
        apply(mk(3, 0) | 32'h1, 32'hFFFF_FFFF, 32'h1234_5678);
        chk("R8 illegal flag", {30'd0, valid_o, illegal_o}, 32'h3);
        chk("R8 cr unchanged", cr_o, 32'h1234_5678);
        chk("R8 fpscr unchanged", fpscr_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_reserved;
        apply(mk(3, 0) | (32'h1 << 22), 32'hA5A5_A5A5, 32'h0BAD_F00D);
        chk("R9 illegal (22)", {31'd0, illegal_o}, 32'h1);
        chk("R9 cr pass", cr_o, 32'h0BAD_F00D);
        chk("R9 fpscr pass", fpscr_o, 32'hA5A5_A5A5);
        apply(mk(3, 0) | (32'h1 << 12), 32'hA5A5_A5A5, 32'h0BAD_F00D);
        chk("R9 illegal (12)", {31'd0, illegal_o}, 32'h1);
        chk("R9 fpscr pass", fpscr_o, 32'hA5A5_A5A5);
    endtask

    task automatic t_nomatch;
        apply(32'hFC00_0082, 32'hFFFF_FFFF, 32'h5555_AAAA);
        chk("R10 valid low", {30'd0, valid_o, illegal_o}, 32'h0);
        chk("R10 cr pass", cr_o, 32'h5555_AAAA);
        chk("R10 fpscr pass", fpscr_o, 32'hFFFF_FFFF);
        apply(32'hF800_0080, 32'h1, 32'h2);
        chk("R1 primary mismatch", {31'd0, valid_o}, 32'h0);
    endtask

    task automatic t_sweep;
        for (int d = 0; d < 8; d++) begin
            for (int s = 0; s < 8; s++) begin
                logic [31:0] f;
                logic [31:0] c;
                logic [63:0] e;
                f = 32'h9E37_79B9 ^ (32'(s) * 32'h1111_1111) ^ 32'(d << 8);
                c = 32'hC3A5_5A3C ^ 32'(d * 32'h0101_0101);
                e = model(d, s, f, c);
                apply(mk(d, s), f, c);
                chk("R2 sweep cr", cr_o, e[63:32]);
                chk("R4 sweep fpscr", fpscr_o, e[31:0]);
            end
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_field0_all_ones();
        t_vx_drop();
        t_fex_held();
        t_untouched();
        t_rc();
        t_reserved();
        t_nomatch();
        t_sweep();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule